// File: doc/BRIEF.md
# Edge-Triggered Wake-Up Interrupt Aggregator

This block gathers a set of asynchronous wake-up or interrupt lines into one request line for a downstream edge-sensitive interrupt controller. Each line passes through a two-flop synchronizer. It is then watched for a qualifying edge, rising or falling as chosen per line. A detected edge latches into a per-line pending bit. The combined request is the OR of all pending bits whose enable bit is set. The request is registered.

Software works through a small register port that holds three registers: an enable mask, a per-line trigger polarity and the pending set. The pending set is cleared by writing ones. If a clear removes some pending bits while other enabled ones remain, the request drops for one cycle and then rises again. An edge-sensitive controller therefore sees a fresh edge for the events that remain. If the clear empties the enabled set, the request stays low until a new edge arrives.

Top module: `wkagg_top`

## Requirements
- R1: After the synchronous active-high reset, the pending, mask and read-data registers hold zero, every polarity bit is 1 (rising) and the request output is low.
- R2: A line's pending bit is set at the third rising clock edge after the line changes. Polarity bit 1 selects rising edges and polarity bit 0 selects falling edges.
- R3: A line held at a steady level sets its pending bit only once. After software clears the bit, it stays clear while the level holds.
- R4: Edges on several lines in the same cycle set all of their pending bits at the same clock edge.
- R5: Mask bit 1 enables a line. The request output is registered and, outside the cycle named in R6, equals the OR of (pending AND mask) as held after the same clock edge. A pending bit whose mask bit is 0 still latches but does not raise the request.
- R6: A pending-register write that clears at least one set bit while at least one enabled pending bit remains forces the request low for exactly one cycle. The request is high again in the next cycle.
- R7: A write that leaves no enabled pending bit drives the request low. It stays low until a new edge arrives on an enabled line.
- R8: An edge on a line whose pending bit is already set merges into that bit. A single clear removes it.
- R9: Writing 1 to a pending bit clears it and writing 0 leaves it unchanged. When an edge and a clear reach the same bit in one cycle, the bit stays set.
- R10: Register select 0 is the mask, 1 the polarity, 2 the pending set, and 3 reads as zero. Read data is registered and shows the selected register one cycle after the select is presented. Reading changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_in | input | NUM_LINES | Raw asynchronous wake-up lines |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | NUM_LINES | Write data |
| reg_rdata | output | NUM_LINES | Registered read data |
| irq_out | output | 1 | Combined request toward the interrupt controller |

## Verification
Two functions can fall into the same cycle. The first is software's write-one-to-clear on the pending register. The second is the synchronized edge pulse that sets that same bit. The bench counts three clock edges from the line change to the pending update and times the clear write to land on that exact edge. It then reads back the pending register and expects the bit to have survived, with no request drop. A behavioural model, fed the same stimulus, judges the request and read data on every clock; partial-clear drops are additionally checked cycle by cycle.

// File: rtl/wkagg_pkg.sv
package wkagg_pkg;
  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_POL  = 2'd1,
    SEL_PEND = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/wkagg_sync.sv
module wkagg_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] r;
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) r <= '0;
        else     r <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) r <= '0;
        else     r <= g_stage[s-1].r;
      end
    end
  end
  assign q_o = g_stage[STAGES-1].r;
endmodule

// File: rtl/wkagg_edge.sv
module wkagg_edge #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] lvl_i,
  input  logic [WIDTH-1:0] rise_sel_i,
  output logic [WIDTH-1:0] pulse_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl_i;
  end

  assign pulse_o = (rise_sel_i & lvl_i & ~prev_q) | (~rise_sel_i & ~lvl_i & prev_q);

  // A pulse needs a level change seen over one clock
  assert_pulse_change_R2: assert property (@(posedge clk) disable iff (rst)
    ((pulse_o & ~(lvl_i ^ prev_q)) == '0));
endmodule

// File: rtl/wkagg_pend.sv
module wkagg_pend #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] set_i,
  input  logic             clr_en_i,
  input  logic [WIDTH-1:0] clr_bits_i,
  output logic [WIDTH-1:0] pend_o,
  output logic [WIDTH-1:0] pend_nxt_o
);
  logic [WIDTH-1:0] pend_q;
  logic [WIDTH-1:0] clr_eff;

  assign clr_eff    = clr_en_i ? clr_bits_i : '0;
  assign pend_nxt_o = (pend_q & ~clr_eff) | set_i;
  assign pend_o     = pend_q;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_nxt_o;
  end

  assert_set_by_edge_R2: assert property (@(posedge clk) disable iff (rst)
    ((pend_q & ~$past(pend_q) & ~$past(set_i)) == '0));
  assert_edge_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (($past(set_i) & ~pend_q) == '0));
  assert_w1c_R9: assert property (@(posedge clk) disable iff (rst)
    ((pend_q & $past(clr_eff & ~set_i)) == '0));
endmodule

// File: rtl/wkagg_top.sv
module wkagg_top
  import wkagg_pkg::*;
#(
  parameter int NUM_LINES   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] wake_in,
  input  logic                 reg_wr,
  input  logic [1:0]           reg_sel,
  input  logic [NUM_LINES-1:0] reg_wdata,
  output logic [NUM_LINES-1:0] reg_rdata,
  output logic                 irq_out
);
  localparam logic [NUM_LINES-1:0] POL_RESET = {NUM_LINES{1'b1}};

  logic [NUM_LINES-1:0] sync_lvl;
  logic [NUM_LINES-1:0] edge_pulse;
  logic [NUM_LINES-1:0] pend;
  logic [NUM_LINES-1:0] pend_nxt;
  logic [NUM_LINES-1:0] mask_q;
  logic [NUM_LINES-1:0] pol_q;
  logic [NUM_LINES-1:0] rdata_q;
  logic                 irq_q;
  logic                 wr_pend;
  logic                 any_next;
  logic                 partial_clr;
  reg_sel_e             sel;

  assign sel     = reg_sel_e'(reg_sel);
  assign wr_pend = reg_wr && (sel == SEL_PEND);

  wkagg_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(wake_in), .q_o(sync_lvl));

  wkagg_edge #(.WIDTH(NUM_LINES)) u_edge (
    .clk(clk), .rst(rst), .lvl_i(sync_lvl), .rise_sel_i(pol_q), .pulse_o(edge_pulse));

  wkagg_pend #(.WIDTH(NUM_LINES)) u_pend (
    .clk(clk), .rst(rst), .set_i(edge_pulse), .clr_en_i(wr_pend),
    .clr_bits_i(reg_wdata), .pend_o(pend), .pend_nxt_o(pend_nxt));

  // Configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      pol_q  <= POL_RESET;
    end else if (reg_wr) begin
      if (sel == SEL_MASK) mask_q <= reg_wdata;
      if (sel == SEL_POL)  pol_q  <= reg_wdata;
    end
  end

  // Registered read port, free of side effects
  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else begin
      unique case (sel)
        SEL_MASK: rdata_q <= mask_q;
        SEL_POL:  rdata_q <= pol_q;
        SEL_PEND: rdata_q <= pend;
        default:  rdata_q <= '0;
      endcase
    end
  end

  // Combined request. A pending write leaves the mask unchanged, so
  // the mask value for the next state is the current one.
  assign any_next    = |(pend_nxt & (reg_wr && sel == SEL_MASK ? reg_wdata : mask_q));
  assign partial_clr = wr_pend && (|(reg_wdata & pend & ~edge_pulse)) && any_next;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= any_next && !partial_clr;
  end

  assign irq_out   = irq_q;
  assign reg_rdata = rdata_q;

  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (!irq_q && pend == '0));
  assert_req_source_R5: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (|(pend & mask_q)));
  assert_partial_drop_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_pend && (|(reg_wdata & pend & ~edge_pulse)) && (|(((pend & ~reg_wdata) | edge_pulse) & mask_q)))
      |=> !irq_q);
  assert_full_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_pend && ((((pend & ~reg_wdata) | edge_pulse) & mask_q) == '0)) |=> !irq_q);
  assert_reassert_R6: assert property (@(posedge clk) disable iff (rst)
    ($fell(irq_q) && (|(pend & mask_q)) && !reg_wr) |=> irq_q);
endmodule

// File: tb/wkagg_top_tb.sv
`timescale 1ns/1ps
module wkagg_top_tb;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] wake_in;
  logic         reg_wr;
  logic [1:0]   reg_sel;
  logic [N-1:0] reg_wdata;
  logic [N-1:0] reg_rdata;
  logic         irq_out;

  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  wkagg_top #(.NUM_LINES(N)) u_dut (
    .clk(clk), .rst(rst), .wake_in(wake_in), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out));

  // Behavioural reference model
  logic [N-1:0] hist[$];
  logic [N-1:0] m_mask, m_pol, m_pend, m_rdata;
  logic         m_irq;

  always @(posedge clk) begin
    logic [N-1:0] ev, clr, nxt_pend, nxt_mask, nxt_pol;
    bit drop;
    if (rst) begin
      hist = {'0, '0, '0};
      m_mask = '0; m_pol = '1; m_pend = '0; m_rdata = '0; m_irq = 0;
    end else begin
      ev = (m_pol & hist[1] & ~hist[2]) | (~m_pol & ~hist[1] & hist[2]);
      clr = (reg_wr && reg_sel == 2'd2) ? reg_wdata : '0;
      nxt_pend = (m_pend & ~clr) | ev;
      nxt_mask = (reg_wr && reg_sel == 2'd0) ? reg_wdata : m_mask;
      nxt_pol  = (reg_wr && reg_sel == 2'd1) ? reg_wdata : m_pol;
      drop = ((clr & m_pend & ~ev) != 0) && ((nxt_pend & nxt_mask) != 0);
      case (reg_sel)
        2'd0: m_rdata = m_mask;
        2'd1: m_rdata = m_pol;
        2'd2: m_rdata = m_pend;
        default: m_rdata = '0;
      endcase
      m_irq  = ((nxt_pend & nxt_mask) != 0) && !drop;
      m_pend = nxt_pend; m_mask = nxt_mask; m_pol = nxt_pol;
      hist.push_front(wake_in);
      void'(hist.pop_back());
    end
  end

  task automatic chk(string req, string what, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Compare with the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(cur_req, "irq vs model", {{(N-1){1'b0}}, irq_out}, {{(N-1){1'b0}}, m_irq});
      chk(cur_req, "rdata vs model", reg_rdata, m_rdata);
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [N-1:0] data);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [N-1:0] val);
    @(negedge clk);
    reg_sel = sel;
    @(negedge clk);
    val = reg_rdata;
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [N-1:0] v, v2;
    rst = 1'b1; wake_in = '0; reg_wr = 1'b0; reg_sel = 2'd0; reg_wdata = '0;
    settle(3);
    @(negedge clk) rst = 1'b0;

    cur_req = "R1";
    chk("R1", "irq after reset", {{(N-1){1'b0}}, irq_out}, '0);
    rd(2'd2, v); chk("R1", "pending after reset", v, '0);
    rd(2'd1, v); chk("R1", "polarity after reset", v, '1);
    rd(2'd0, v); chk("R1", "mask after reset", v, '0);

    cur_req = "R10";
    wr(2'd0, 8'hFF);
    rd(2'd0, v); chk("R10", "mask readback", v, 8'hFF);
    rd(2'd3, v); chk("R10", "select 3 reads zero", v, '0);

    // R2: rising edge on line 0, pending at third clock edge
    cur_req = "R2";
    reg_sel = 2'd2;
    @(negedge clk) wake_in[0] = 1'b1;
    settle(2);
    chk("R2", "not yet pending after two edges", {{(N-1){1'b0}}, irq_out}, '0);
    settle(1);
    chk("R2", "irq at third edge", {{(N-1){1'b0}}, irq_out}, 1);

    // R3: level held, clear, stays clear
    cur_req = "R3";
    wr(2'd2, 8'h01);
    settle(6);
    rd(2'd2, v); chk("R3", "held level does not re-set", v, '0);
    chk("R3", "irq low after clear", {{(N-1){1'b0}}, irq_out}, '0);

    // R4: simultaneous edges
    cur_req = "R4";
    @(negedge clk) wake_in[3:1] = 3'b111;
    settle(4);
    rd(2'd2, v); chk("R4", "three lines pending together", v, 8'h0E);

    // R6: partial clear drops for exactly one cycle
    cur_req = "R6";
    wr(2'd2, 8'h02);
    chk("R6", "irq low after partial clear", {{(N-1){1'b0}}, irq_out}, 0);
    settle(1);
    chk("R6", "irq high next cycle", {{(N-1){1'b0}}, irq_out}, 1);
    wr(2'd2, 8'h04);
    chk("R6", "second partial clear drop", {{(N-1){1'b0}}, irq_out}, 0);
    settle(1);
    chk("R6", "second reassert", {{(N-1){1'b0}}, irq_out}, 1);

    // R7: full clear stays low
    cur_req = "R7";
    wr(2'd2, 8'hFF);
    settle(5);
    chk("R7", "irq stays low after full clear", {{(N-1){1'b0}}, irq_out}, 0);

    // R2 falling polarity on line 4
    cur_req = "R2";
    wr(2'd1, 8'hEF);
    @(negedge clk) wake_in[4] = 1'b1;
    settle(5);
    rd(2'd2, v); chk("R2", "rising ignored on falling line", v, '0);
    @(negedge clk) wake_in[4] = 1'b0;
    settle(4);
    rd(2'd2, v); chk("R2", "falling edge latched", v, 8'h10);
    wr(2'd2, 8'h10);

    // R8: merge of repeated edges
    cur_req = "R8";
    for (int k = 0; k < 2; k++) begin
      @(negedge clk) wake_in[5] = 1'b1;
      settle(4);
      @(negedge clk) wake_in[5] = 1'b0;
      settle(4);
    end
    rd(2'd2, v); chk("R8", "two edges one bit", v, 8'h20);
    wr(2'd2, 8'h20);
    rd(2'd2, v); chk("R8", "single clear removes merged", v, '0);

    // R9: write zero has no effect, edge beats clear
    cur_req = "R9";
    @(negedge clk) wake_in[6] = 1'b1;
    settle(4);
    @(negedge clk) wake_in[6] = 1'b0;
    settle(4);
    wr(2'd2, 8'h00);
    rd(2'd2, v); chk("R9", "write zero keeps bit", v, 8'h40);
    @(negedge clk) wake_in[6] = 1'b1;
    @(negedge clk);
    wr(2'd2, 8'h40);
    rd(2'd2, v); chk("R9", "edge wins over clear", v, 8'h40);
    chk("R9", "no drop when clear loses", {{(N-1){1'b0}}, irq_out}, 1);
    wr(2'd2, 8'h40);

    // R5: masked line latches without request
    cur_req = "R5";
    wr(2'd0, 8'h7F);
    @(negedge clk) wake_in[7] = 1'b1;
    settle(5);
    rd(2'd2, v); chk("R5", "masked line still pending", v, 8'h80);
    chk("R5", "masked pending gives no irq", {{(N-1){1'b0}}, irq_out}, 0);
    wr(2'd0, 8'hFF);
    chk("R5", "unmask raises irq", {{(N-1){1'b0}}, irq_out}, 1);

    // R10: reads have no side effect
    cur_req = "R10";
    rd(2'd2, v); rd(2'd2, v2);
    chk("R10", "repeated read stable", v2, v);
    chk("R10", "irq unchanged by reads", {{(N-1){1'b0}}, irq_out}, 1);
    wr(2'd2, 8'hFF);
    settle(2);
    finish_run();
  end
endmodule